// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous request port and an external asynchronous static RAM of 131072 bytes. A client presents an address, a direction and, for stores, a byte. The request is taken with a valid/ready handshake. The controller then builds a complete memory cycle on the external pins: a 17-bit address, active-low chip select, write strobe and output enable, and a shared 8-bit data bus. The data bus appears as separate drive-value, sampled-value and drive-enable signals.

A store runs in three phases. First, one setup cycle drives the address and data with both strobes high. Next, chip select and the write strobe are pulled low together for a programmable number of cycles. Last, one hold cycle keeps the address and data driven after both strobes have risen. The memory latches data on whichever strobe rises first, so this order meets setup and hold against either edge. A load holds chip select and output enable low for a programmable number of access cycles. The byte on the bus is sampled at the end of the last access cycle and returned with a one-cycle valid pulse. When the direction changes between two requests, the controller inserts one cycle with the memory deselected and the bus released. Whenever no cycle is running, chip select stays high, which puts the memory in standby.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: Whenever `req_ready` is 1 (no cycle in progress), `mem_cs_n` is 1.
- R3: A write accepted at clock edge E (with no turnaround) shows the following on the pins. In the cycle after E, `mem_dq_oe`=1, the address and data are on the pins, and `mem_cs_n`=`mem_we_n`=1. The next WR_PULSE cycles have `mem_cs_n`=`mem_we_n`=0. One more cycle has both strobes at 1 while the address and data are still driven. In the cycle after that, `mem_dq_oe`=0.
- R4: Whenever `mem_dq_oe` is 1, `mem_oe_n` is 1. `mem_we_n` is 0 only while `mem_dq_oe` is 1 and `mem_cs_n` is 0. The memory and the controller never drive the bus in the same cycle.
- R5: A read accepted at edge E (with no turnaround) holds `mem_cs_n`=`mem_oe_n`=0 and `mem_we_n`=1 for RD_WAIT cycles, with the bus released. The bus is sampled at the end of the last of these cycles. In the following cycle, `rsp_valid` is 1 for exactly one cycle with the sampled byte on `rsp_rdata`, and `mem_cs_n` is back at 1.
- R6: `mem_addr` does not change while `mem_cs_n` stays 0, and it does not change on the cycle in which `mem_we_n` rises.
- R7: A read accepted after a write, or a write accepted after a read, first spends one cycle with `mem_cs_n`=1, `mem_dq_oe`=0 and `req_ready`=0. The R3/R5 sequence then starts one cycle later. Requests in the same direction get no such cycle.
- R8: A request is taken only at an edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the edge of acceptance until the last cycle of the memory cycle. A request held valid while `req_ready` is 0 has no effect.
- R9: A byte written to an address and later read back returns unchanged, including at addresses 0x00000 and 0x1FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Byte read from memory |
| mem_addr | output | 17 | Memory address pins |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | 8 | Value driven onto the data bus |
| mem_dq_in | input | 8 | Value sampled from the data bus |
| mem_dq_oe | output | 1 | Controller drives the data bus when 1 |

## Verification
The properties assume that the client obeys the handshake. Address, direction and data are only taken at an edge where both valid and ready are high, and a read's byte is assumed to be on `mem_dq_in` by the end of the access window. The bench drives requests only at falling edges and holds them until acceptance. Its memory model answers a read at the falling edge after output enable drops, which is within the window for any RD_WAIT of at least 1. A deliberate request held during a busy write probes the ignore rule without breaking the handshake.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_TURN   = 3'd1,
    ST_WSET   = 3'd2,
    ST_WPULSE = 3'd3,
    ST_WHOLD  = 3'd4,
    ST_RACC   = 3'd5
  } state_t;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } strobe_t;

  localparam strobe_t STROBE_OFF = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

  // Pin levels that belong to each phase of a memory cycle.
  function automatic strobe_t strobe_of(state_t s);
    strobe_t r;
    r = STROBE_OFF;
    case (s)
      ST_WSET:   r.dq_oe = 1'b1;
      ST_WPULSE: begin
        r.cs_n  = 1'b0;
        r.we_n  = 1'b0;
        r.dq_oe = 1'b1;
      end
      ST_WHOLD:  r.dq_oe = 1'b1;
      ST_RACC:   begin
        r.cs_n = 1'b0;
        r.oe_n = 1'b0;
      end
      default:   r = STROBE_OFF;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/asram_wait_cnt.sv
module asram_wait_cnt #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] init,
  input  logic         run,
  output logic         zero
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign cnt_en = load | (run & ~zero);

  always_comb begin
    if (load) cnt_d = init;
    else      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int RD_WAIT  = 2,
  parameter int WR_PULSE = 2,
  parameter int CNT_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_we,
  input  logic             cnt_zero,
  output state_t           state_q,
  output state_t           state_d,
  output logic             accept,
  output logic             ready,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_init,
  output logic             cnt_run
);

  logic seen_q;
  logic last_we_q;
  logic turn_needed;

  assign ready       = (state_q == ST_IDLE);
  assign turn_needed = seen_q & (last_we_q != req_we);

  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          if (turn_needed)  state_d = ST_TURN;
          else if (req_we)  state_d = ST_WSET;
          else              state_d = ST_RACC;
        end
      end
      ST_TURN:   state_d = last_we_q ? ST_WSET : ST_RACC;
      ST_WSET:   state_d = ST_WPULSE;
      ST_WPULSE: if (cnt_zero) state_d = ST_WHOLD;
      ST_WHOLD:  state_d = ST_IDLE;
      ST_RACC:   if (cnt_zero) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cnt_load = ((state_d == ST_WPULSE) && (state_q != ST_WPULSE)) ||
               ((state_d == ST_RACC)   && (state_q != ST_RACC));
    cnt_init = (state_d == ST_WPULSE) ? CNT_W'(WR_PULSE - 1) : CNT_W'(RD_WAIT - 1);
    cnt_run  = (state_q == ST_WPULSE) || (state_q == ST_RACC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q    <= 1'b0;
      last_we_q <= 1'b0;
    end else if (accept) begin
      seen_q    <= 1'b1;
      last_we_q <= req_we;
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int RD_WAIT  = 2,
  parameter int WR_PULSE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  localparam int MAX_WAIT = (RD_WAIT > WR_PULSE) ? RD_WAIT : WR_PULSE;
  localparam int CNT_W    = (MAX_WAIT < 2) ? 1 : $clog2(MAX_WAIT);

  state_t             state_q;
  state_t             state_d;
  logic               accept;
  logic               cnt_load;
  logic [CNT_W-1:0]   cnt_init;
  logic               cnt_run;
  logic               cnt_zero;
  logic               capture;

  strobe_t            strb_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [DATA_W-1:0]  rdata_q;
  logic               rvalid_q;

  asram_fsm #(
    .RD_WAIT (RD_WAIT),
    .WR_PULSE(WR_PULSE),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_we   (req_we),
    .cnt_zero (cnt_zero),
    .state_q  (state_q),
    .state_d  (state_d),
    .accept   (accept),
    .ready    (req_ready),
    .cnt_load (cnt_load),
    .cnt_init (cnt_init),
    .cnt_run  (cnt_run)
  );

  asram_wait_cnt #(
    .W(CNT_W)
  ) u_wait (
    .clk  (clk),
    .rst_n(rst_n),
    .load (cnt_load),
    .init (cnt_init),
    .run  (cnt_run),
    .zero (cnt_zero)
  );

  // Strobes are registered from the next state so pins change only at edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_q <= STROBE_OFF;
    else        strb_q <= strobe_of(state_d);
  end

  // Request capture; the address stays put until the next acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign capture = (state_q == ST_RACC) & cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (capture) rdata_q <= mem_dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= capture;
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_cs_n   = strb_q.cs_n;
  assign mem_we_n   = strb_q.we_n;
  assign mem_oe_n   = strb_q.oe_n;
  assign mem_dq_oe  = strb_q.dq_oe;
  assign rsp_valid  = rvalid_q;
  assign rsp_rdata  = rdata_q;

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);

  p_idle_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_cs_n);

  p_no_bus_fight_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  p_we_inside_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_dq_oe && !mem_cs_n));

  p_addr_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  p_hold_after_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_out)));

  p_release_late_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_dq_oe) |-> (mem_cs_n && mem_we_n && $past(mem_cs_n) && $past(mem_we_n)));

  p_rsp_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_busy_after_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_cs_n  (mem_cs_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_out(mem_dq_out),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/asram_ctrl_test.sv
`timescale 1ns/1ps
module asram_ctrl_test;

  localparam int AW     = 17;
  localparam int DW     = 8;
  localparam int RWAIT  = 3;
  localparam int WPULSE = 2;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic          req_we;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_cs_n;
  logic          mem_we_n;
  logic          mem_oe_n;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in;
  logic          mem_dq_oe;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done  = 1'b0;

  logic [DW-1:0] dev    [int];
  logic [DW-1:0] shadow [int];
  logic [DW-1:0] exp_q  [$];
  bit have_last = 1'b0;
  bit last_we   = 1'b0;

  asram_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .RD_WAIT(RWAIT), .WR_PULSE(WPULSE)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Memory model: latches on the end of the write overlap, answers reads at falling edges.
  logic wr_active;
  logic dev_drive;
  assign wr_active = !mem_cs_n && !mem_we_n;
  assign dev_drive = !mem_cs_n && !mem_oe_n && mem_we_n;

  always @(negedge wr_active) begin
    if (mem_dq_oe === 1'b1) dev[int'(mem_addr)] = mem_dq_out;
  end

  always @(negedge clk) begin
    if (dev_drive) mem_dq_in <= dev.exists(int'(mem_addr)) ? dev[int'(mem_addr)] : 8'h00;
    else           mem_dq_in <= 8'hEE;
    if (rst_n && dev_drive && mem_dq_oe)
      chk(1'b0, "R4", "bus contention", 1, 0);
  end

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R5", "unexpected rsp_valid", 1, 0);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(rsp_rdata == e, "R9", "read data", int'(rsp_rdata), int'(e));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic take(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = a;
    req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic turn_check(input bit we);
    if (have_last && last_we != we) begin
      chk(mem_cs_n == 1'b1 && mem_dq_oe == 1'b0 && req_ready == 1'b0, "R7",
          "turnaround cycle", {mem_cs_n, mem_dq_oe, req_ready}, 3'b100);
      @(negedge clk);
    end
    have_last = 1'b1;
    last_we   = we;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit poke);
    take(1'b1, a, d);
    if (poke) begin
      req_valid = 1'b1;
      req_we    = 1'b1;
      req_addr  = a ^ 17'h1;
      req_wdata = ~d;
    end
    turn_check(1'b1);
    shadow[int'(a)] = d;
    chk(mem_cs_n && mem_we_n && mem_dq_oe && mem_addr == a && mem_dq_out == d, "R3",
        "write setup", {mem_cs_n, mem_we_n, mem_dq_oe}, 3'b111);
    chk(req_ready == 1'b0, "R8", "busy in setup", int'(req_ready), 0);
    for (int k = 0; k < WPULSE; k++) begin
      @(negedge clk);
      chk(!mem_cs_n && !mem_we_n && mem_dq_out == d, "R3", "write pulse",
          {mem_cs_n, mem_we_n}, 2'b00);
      chk(mem_oe_n == 1'b1, "R4", "oe_n high while writing", int'(mem_oe_n), 1);
      chk(mem_addr == a, "R6", "address during pulse", int'(mem_addr), int'(a));
    end
    @(negedge clk);
    if (poke) req_valid = 1'b0;
    chk(mem_cs_n && mem_we_n && mem_dq_oe && mem_addr == a && mem_dq_out == d, "R3",
        "write hold", {mem_cs_n, mem_we_n, mem_dq_oe}, 3'b111);
    chk(req_ready == 1'b0, "R8", "busy in hold", int'(req_ready), 0);
    @(negedge clk);
    chk(!mem_dq_oe && mem_cs_n, "R3", "bus released", {mem_dq_oe, mem_cs_n}, 2'b01);
    chk(req_ready == 1'b1, "R2", "ready after write", int'(req_ready), 1);
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    logic [DW-1:0] e;
    take(1'b0, a, 8'h00);
    turn_check(1'b0);
    e = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
    exp_q.push_back(e);
    for (int k = 0; k < RWAIT; k++) begin
      chk(!mem_cs_n && !mem_oe_n && mem_we_n && !mem_dq_oe, "R5", "read access",
          {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0010);
      chk(mem_addr == a && req_ready == 1'b0, "R6", "read address/busy",
          int'(mem_addr), int'(a));
      @(negedge clk);
    end
    chk(rsp_valid == 1'b1 && mem_cs_n == 1'b1, "R5", "response cycle",
        {rsp_valid, mem_cs_n}, 2'b11);
    chk(req_ready == 1'b1, "R8", "ready after read", int'(req_ready), 1);
  endtask

  initial begin
    req_valid = 1'b0;
    req_we    = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid, "R1",
        "pins in reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid}, 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && mem_cs_n && !mem_dq_oe, "R1", "after reset",
        {req_ready, mem_cs_n, mem_dq_oe}, 3'b110);
    repeat (2) @(negedge clk);
    chk(mem_cs_n == 1'b1, "R2", "idle standby", int'(mem_cs_n), 1);

    do_write(17'h00000, 8'hA5, 1'b0);
    do_write(17'h1FFFF, 8'h3C, 1'b0);   // same direction: no turnaround (R7)
    do_read(17'h00000);                 // direction change: turnaround (R7)
    do_read(17'h1FFFF);
    do_write(17'h12345, 8'h5A, 1'b1);   // request held while busy is ignored (R8)
    do_read(17'h12345);
    do_read(17'h12344);                 // never written: model returns 0 (R8 poke ignored)
    for (int i = 0; i < 6; i++) begin
      do_write(17'(i * 17'h5A5 + 3), 8'(i * 37 + 1), 1'b0);
      if (i % 2 == 1) do_read(17'((i - 1) * 17'h5A5 + 3));
    end
    for (int i = 0; i < 6; i++) do_read(17'(i * 17'h5A5 + 3));
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R5", "all responses seen", exp_q.size(), 0);
    chk(mem_cs_n == 1'b1, "R2", "final standby", int'(mem_cs_n), 1);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule